// File: doc/BRIEF.md
# Framed Serial Register Access Port

This block is a synchronous serial slave that lets a host reach the internal registers of a data converter. An active-low, level-sensitive frame-sync input bounds each 16-bit transfer. The host supplies a serial clock. Each frame is full duplex: bits arrive on a data-in line and a 16-bit word leaves on a data-out line. A write frame carries a 2-bit register address in its top two bits and 14 data bits below them. The data is committed to the addressed register only when the sixteenth bit has been taken in.

A read frame has no address of its own. It returns the register picked by a sticky read selector held in bits 7:6 of the control register, and that choice stays in force until the control register is rewritten. The ten calibration registers are reached through a pointer. The pointer runs over a group picked by a 2-bit calibration-select field in control bits 1:0, and it moves on after every frame that writes or reads a calibration word. The converter side delivers a 12-bit conversion result and a 14-bit status word. The converter side receives the control, test and calibration contents.

The block runs on a fast system clock. The serial clock, frame sync and data-in are brought into that domain through synchronizers and detected by their edges.

Top module: `serreg_port`

## Requirements
- R1: Frames are MSB first. Data-in is taken on each serial-clock rising edge while frame sync is low. Bits 15:14 of the 16-bit word are the address and bits 13:0 are the data.
- R2: No register changes until the sixteenth rising edge of a frame. If frame sync returns high after fewer bits, the frame commits nothing and the calibration pointer does not move.
- R3: Address 00 commits no register. Its 14 data bits are discarded, and test, control and calibration contents stay as they were.
- R4: Address 01 writes the test register (`test_o`). Address 11 writes the control register (`ctrl_o`).
- R5: Address 10 writes the 14 data bits into the calibration register the pointer currently designates, seen as `cal_o[i*14 +: 14]` for register i.
- R6: The read selector is control bits 7:6 and resets to 00. With 00, the frame returns four zero bits followed by the last captured 12-bit result, taken when `result_vld_i` is high.
- R7: Read selector 01 returns {2'b00, test register}, 10 returns {2'b00, calibration register at the pointer}, and 11 returns {2'b00, status word} as captured on the clock before frame start. The word is fixed at the falling edge of frame sync.
- R8: Data-out presents the MSB after frame sync falls and moves to the next bit after each serial-clock falling edge. It is 0 once frame sync is high again.
- R9: After reset, control, test and all calibration registers are 0 and data-out is 0.
- R10: Register 0 is gain, register 1 is offset and 2..9 are the DAC words. A control write sets the pointer to the start of the group chosen by its bits 1:0: 00 gives 0,1,2..9 with wrap to 0; 01 alternates 0,1; 10 stays at 1; 11 stays at 0. A complete frame that writes address 10, or that starts with read selector 10, advances the pointer one step. A control write takes priority over an advance.
- R11: Serial-clock edges after the sixteenth in a frame are ignored and do not alter the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| sync_n_i | input | 1 | Active-low frame sync |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| result_i | input | 12 | Conversion result from the converter |
| result_vld_i | input | 1 | Captures `result_i` into the output data register |
| status_i | input | 14 | Status word from the converter |
| ctrl_o | output | 14 | Control register contents |
| test_o | output | 14 | Test register contents |
| cal_o | output | 140 | Ten calibration registers, register i at bits i*14+13:i*14 |

## Verification
The assertions take for granted that the serial clock, frame sync and data-in each stay at one level for several system clocks. They also assume the serial clock is low whenever frame sync changes, and that a commit is therefore always seen while the synchronized frame sync is still low. The stimulus holds each serial-clock phase and each frame-sync setup and hold for eight system clocks. It changes data-in only while the serial clock is low. It also changes the result and status inputs only between frames.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    localparam int FRAME_W    = 16;
    localparam int ADDR_W     = 2;
    localparam int DATA_W     = FRAME_W - ADDR_W;
    localparam int RES_W      = 12;
    localparam int CAL_N      = 10;
    localparam int RDSEL_LSB  = 6;
    localparam int CALSEL_LSB = 0;

    typedef enum logic [1:0] {
        ADR_NONE = 2'b00,
        ADR_TEST = 2'b01,
        ADR_CAL  = 2'b10,
        ADR_CTRL = 2'b11
    } wr_addr_e;

    typedef enum logic [1:0] {
        RD_RESULT = 2'b00,
        RD_TEST   = 2'b01,
        RD_CAL    = 2'b10,
        RD_STATUS = 2'b11
    } rd_sel_e;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= rst_val;
        end else begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/serreg_shifter.sv
module serreg_shifter #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sync_n,
    input  logic               sdi,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               load,
    output logic               commit,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   cnt,
    output logic               sdo
);
    typedef struct packed {
        logic               sclk_prev;
        logic               sync_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic               load;
        logic               commit;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.load      = 1'b0;
        st_d.commit    = 1'b0;
        st_d.sclk_prev = sclk;
        st_d.sync_prev = sync_n;
        if (sync_n) begin
            if (!st_q.sync_prev) begin
                st_d.tx  = '0;
                st_d.cnt = '0;
            end
        end else if (st_q.sync_prev) begin
            st_d.tx   = tx_word;
            st_d.cnt  = '0;
            st_d.load = 1'b1;
        end else begin
            if (sclk && !st_q.sclk_prev && (st_q.cnt < CNT_W'(FRAME_W))) begin
                st_d.rx  = {st_q.rx[FRAME_W-2:0], sdi};
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(FRAME_W - 1)) st_d.commit = 1'b1;
            end
            if (!sclk && st_q.sclk_prev) begin
                st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sync_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load   = st_q.load;
    assign commit = st_q.commit;
    assign word   = st_q.rx;
    assign cnt    = st_q.cnt;
    assign sdo    = st_q.tx[FRAME_W-1];
endmodule

// File: rtl/serreg_regfile.sv
module serreg_regfile
    import serreg_pkg::*;
#(
    parameter int FRAME_W = serreg_pkg::FRAME_W,
    parameter int RES_W   = serreg_pkg::RES_W,
    parameter int CAL_N   = serreg_pkg::CAL_N,
    localparam int DATA_W = FRAME_W - ADDR_W,
    localparam int PTR_W  = $clog2(CAL_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    commit,
    input  logic [FRAME_W-1:0]      word,
    input  logic [RES_W-1:0]        result_i,
    input  logic                    result_vld_i,
    input  logic [DATA_W-1:0]       status_i,
    output logic [FRAME_W-1:0]      tx_word,
    output logic [DATA_W-1:0]       ctrl_o,
    output logic [DATA_W-1:0]       test_o,
    output logic [CAL_N*DATA_W-1:0] cal_o,
    output logic [PTR_W-1:0]        ptr_o
);
    typedef struct packed {
        logic [DATA_W-1:0]             ctrl;
        logic [DATA_W-1:0]             test;
        logic [CAL_N-1:0][DATA_W-1:0]  cal;
        logic [RES_W-1:0]              result;
        logic [DATA_W-1:0]             status;
        logic [PTR_W-1:0]              ptr;
        logic                          frame_cal;
    } regs_t;

    regs_t rg_d, rg_q;

    wr_addr_e          addr;
    logic [DATA_W-1:0] data;
    rd_sel_e           rd_sel;
    logic [1:0]        cal_sel;

    function automatic logic [PTR_W-1:0] grp_start(input logic [1:0] sel);
        return (sel == 2'b10) ? PTR_W'(1) : PTR_W'(0);
    endfunction

    function automatic logic [PTR_W-1:0] grp_next(input logic [PTR_W-1:0] p,
                                                  input logic [1:0] sel);
        logic [PTR_W-1:0] nx;
        case (sel)
            2'b00:   nx = (p == PTR_W'(CAL_N - 1)) ? '0 : p + 1'b1;
            2'b01:   nx = (p == PTR_W'(0)) ? PTR_W'(1) : PTR_W'(0);
            2'b10:   nx = PTR_W'(1);
            default: nx = PTR_W'(0);
        endcase
        return nx;
    endfunction

    assign addr    = wr_addr_e'(word[FRAME_W-1 -: ADDR_W]);
    assign data    = word[DATA_W-1:0];
    assign rd_sel  = rd_sel_e'(rg_q.ctrl[RDSEL_LSB +: 2]);
    assign cal_sel = rg_q.ctrl[CALSEL_LSB +: 2];

    always_comb begin
        rg_d        = rg_q;
        rg_d.status = status_i;
        if (result_vld_i) rg_d.result = result_i;
        if (load) rg_d.frame_cal = (rd_sel == RD_CAL);
        if (commit) begin
            case (addr)
                ADR_TEST: rg_d.test = data;
                ADR_CAL:  rg_d.cal[rg_q.ptr] = data;
                ADR_CTRL: rg_d.ctrl = data;
                default:  ;
            endcase
            if (addr == ADR_CTRL) begin
                rg_d.ptr = grp_start(data[CALSEL_LSB +: 2]);
            end else if (addr == ADR_CAL || rg_q.frame_cal) begin
                rg_d.ptr = grp_next(rg_q.ptr, cal_sel);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (rd_sel)
            RD_RESULT: tx_word = {{(FRAME_W - RES_W){1'b0}}, rg_q.result};
            RD_TEST:   tx_word = {{ADDR_W{1'b0}}, rg_q.test};
            RD_CAL:    tx_word = {{ADDR_W{1'b0}}, rg_q.cal[rg_q.ptr]};
            default:   tx_word = {{ADDR_W{1'b0}}, rg_q.status};
        endcase
    end

    assign ctrl_o = rg_q.ctrl;
    assign test_o = rg_q.test;
    assign cal_o  = rg_q.cal;
    assign ptr_o  = rg_q.ptr;
endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
#(
    parameter int FRAME_W     = serreg_pkg::FRAME_W,
    parameter int RES_W       = serreg_pkg::RES_W,
    parameter int CAL_N       = serreg_pkg::CAL_N,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = FRAME_W - ADDR_W,
    localparam int CNT_W      = $clog2(FRAME_W + 1),
    localparam int PTR_W      = $clog2(CAL_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_i,
    input  logic                    sync_n_i,
    input  logic                    sdi_i,
    output logic                    sdo_o,
    input  logic [RES_W-1:0]        result_i,
    input  logic                    result_vld_i,
    input  logic [DATA_W-1:0]       status_i,
    output logic [DATA_W-1:0]       ctrl_o,
    output logic [DATA_W-1:0]       test_o,
    output logic [CAL_N*DATA_W-1:0] cal_o
);
    logic [2:0]         pins_s;
    logic               sclk_s, sync_n_s, sdi_s;
    logic               sh_load, sh_commit;
    logic [FRAME_W-1:0] sh_word, rf_tx_word;
    logic [CNT_W-1:0]   sh_cnt;
    logic [PTR_W-1:0]   cal_ptr;

    serreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b010),
        .d       ({sclk_i, sync_n_i, sdi_i}),
        .q       (pins_s)
    );

    assign {sclk_s, sync_n_s, sdi_s} = pins_s;

    serreg_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (sclk_s),
        .sync_n  (sync_n_s),
        .sdi     (sdi_s),
        .tx_word (rf_tx_word),
        .load    (sh_load),
        .commit  (sh_commit),
        .word    (sh_word),
        .cnt     (sh_cnt),
        .sdo     (sdo_o)
    );

    serreg_regfile #(.FRAME_W(FRAME_W), .RES_W(RES_W), .CAL_N(CAL_N)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (sh_load),
        .commit       (sh_commit),
        .word         (sh_word),
        .result_i     (result_i),
        .result_vld_i (result_vld_i),
        .status_i     (status_i),
        .tx_word      (rf_tx_word),
        .ctrl_o       (ctrl_o),
        .test_o       (test_o),
        .cal_o        (cal_o),
        .ptr_o        (cal_ptr)
    );
endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk #(
    parameter int FRAME_W = 16,
    parameter int CAL_N   = 10,
    localparam int DATA_W = FRAME_W - 2,
    localparam int CNT_W  = $clog2(FRAME_W + 1),
    localparam int PTR_W  = $clog2(CAL_N)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sync_n_s,
    input logic                    sdo_o,
    input logic                    sh_commit,
    input logic [FRAME_W-1:0]      sh_word,
    input logic [CNT_W-1:0]        sh_cnt,
    input logic [PTR_W-1:0]        cal_ptr,
    input logic [DATA_W-1:0]       ctrl_o,
    input logic [DATA_W-1:0]       test_o,
    input logic [CAL_N*DATA_W-1:0] cal_o
);
    logic [1:0] wr_adr;
    assign wr_adr = sh_word[FRAME_W-1 -: 2];

    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_commit && wr_adr == 2'b11) |=> $stable(ctrl_o));

    assert_test_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_commit && wr_adr == 2'b01) |=> $stable(test_o));

    assert_cal_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_commit && wr_adr == 2'b10) |=> $stable(cal_o));

    assert_commit_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_commit |-> !sync_n_s);

    assert_count_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sh_cnt <= CNT_W'(FRAME_W));

    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ptr < PTR_W'(CAL_N));

    assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n_s && $past(sync_n_s)) |-> !sdo_o);
endmodule

bind serreg_port serreg_port_chk #(.FRAME_W(FRAME_W), .CAL_N(CAL_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n_s  (sync_n_s),
    .sdo_o     (sdo_o),
    .sh_commit (sh_commit),
    .sh_word   (sh_word),
    .sh_cnt    (sh_cnt),
    .cal_ptr   (cal_ptr),
    .ctrl_o    (ctrl_o),
    .test_o    (test_o),
    .cal_o     (cal_o)
);

// File: tb/serreg_port_tb.sv
module serreg_port_tb;
    localparam int HALF = 8;
    localparam int NCAL = 10;
    localparam int WD   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, sync_n = 1'b1, sdi = 1'b0;
    logic         sdo;
    logic [11:0]  result = '0;
    logic         result_vld = 1'b0;
    logic [13:0]  status = '0;
    logic [13:0]  ctrl, test;
    logic [139:0] cal;

    int checks = 0, fails = 0;

    logic [13:0] m_ctrl, m_test, m_res14, m_status;
    logic [13:0] m_cal [NCAL];
    int          m_ptr;
    logic [11:0] m_result;

    always #5 clk = ~clk;

    serreg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdi_i(sdi),
        .sdo_o(sdo), .result_i(result), .result_vld_i(result_vld), .status_i(status),
        .ctrl_o(ctrl), .test_o(test), .cal_o(cal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int grp_start(input logic [1:0] s);
        return (s == 2'b10) ? 1 : 0;
    endfunction

    function automatic int grp_next(input int p, input logic [1:0] s);
        case (s)
            2'b00:   return (p == NCAL - 1) ? 0 : p + 1;
            2'b01:   return (p == 0) ? 1 : 0;
            2'b10:   return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] model_read();
        case (m_ctrl[7:6])
            2'b00:   return {4'h0, m_result};
            2'b01:   return {2'b00, m_test};
            2'b10:   return {2'b00, m_cal[m_ptr]};
            default: return {2'b00, m_status};
        endcase
    endfunction

    task automatic check_regs(input string tag);
        logic [139:0] exp_cal;
        for (int i = 0; i < NCAL; i++) exp_cal[i*14 +: 14] = m_cal[i];
        check({tag, " ctrl"}, 32'(ctrl), 32'(m_ctrl));
        check({tag, " test"}, 32'(test), 32'(m_test));
        checks++;
        if (cal !== exp_cal) begin
            fails++;
            $display("FAIL %s cal actual=%h expected=%h", tag, cal, exp_cal);
        end
    endtask

    // One frame of nbits serial clocks; checks the read word against the model.
    task automatic frame(input logic [15:0] w, input int nbits, input string rtag);
        logic [15:0] rd = '0;
        logic [15:0] exp_rd;
        logic [15:0] mask = '0;
        logic        fc;
        exp_rd = model_read();
        fc     = (m_ctrl[7:6] == 2'b10);
        @(negedge clk); sync_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 16) begin
                rd[15-i]   = sdo;
                mask[15-i] = 1'b1;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        sync_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        check({rtag, " read word"}, 32'(rd & mask), 32'(exp_rd & mask));
        if (nbits >= 16) begin
            case (w[15:14])
                2'b01:   m_test = w[13:0];
                2'b10:   m_cal[m_ptr] = w[13:0];
                2'b11:   m_ctrl = w[13:0];
                default: ;
            endcase
            if (w[15:14] == 2'b11) m_ptr = grp_start(w[1:0]);
            else if (w[15:14] == 2'b10 || fc) m_ptr = grp_next(m_ptr, m_ctrl[1:0]);
        end
    endtask

    function automatic string rd_tag();
        return (m_ctrl[7:6] == 2'b00) ? "R6" : "R7";
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        m_ctrl = '0; m_test = '0; m_status = '0; m_result = '0; m_ptr = 0; m_res14 = '0;
        for (int i = 0; i < NCAL; i++) m_cal[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset state
        check_regs("R9");
        check("R9 sdo", 32'(sdo), 32'd0);

        // R6: default selector returns result with four leading zeros
        result = 12'hABC; result_vld = 1'b1; @(negedge clk); result_vld = 1'b0;
        m_result = 12'hABC;
        status = 14'h2ABC; m_status = 14'h2ABC; @(negedge clk);
        frame({2'b00, 14'h1234}, 16, "R6");
        check_regs("R3");

        // R1: bit order of a write
        frame({2'b01, 14'h2001}, 16, rd_tag());
        check("R1 test bit order", 32'(test), 32'h2001);

        // Sweep of all addresses with computed patterns
        for (int a = 0; a < 4; a++) begin
            for (int p = 0; p < 6; p++) begin
                logic [13:0] d;
                string       t;
                d = 14'((p * 32'h0A53) ^ (a * 32'h1111) ^ (p << 11));
                t = (a == 0) ? "R3" : (a == 2) ? "R5" : "R4";
                frame({2'(a), d}, 16, rd_tag());
                check_regs(t);
            end
        end

        // R2: aborted frames commit nothing
        frame({2'b11, 14'h3FFF}, 10, "R2");
        check_regs("R2");
        frame({2'b10, 14'h1111}, 15, "R2");
        check_regs("R2");

        // R11: edges beyond the sixteenth are ignored
        frame({2'b01, 14'h2468}, 20, rd_tag());
        check("R11 test", 32'(test), 32'h2468);
        check_regs("R11");

        // R10: calibration pointer groups
        for (int s = 0; s < 4; s++) begin
            frame({2'b11, 14'((2 << 6) | s)}, 16, rd_tag());
            check_regs("R10");
            for (int k = 0; k < 11; k++) begin
                frame({2'b10, 14'(s * 32'h100 + k + 1)}, 16, "R7");
                check_regs("R5");
            end
            for (int k = 0; k < 11; k++) begin
                frame({2'b00, 14'h0}, 16, "R10");
            end
        end

        // R7: status and test reads
        frame({2'b11, 14'(3 << 6)}, 16, rd_tag());
        frame({2'b00, 14'h0}, 16, "R7 status");
        status = 14'h1357; m_status = 14'h1357; @(negedge clk);
        frame({2'b00, 14'h0}, 16, "R7 status");
        frame({2'b11, 14'(1 << 6)}, 16, rd_tag());
        frame({2'b00, 14'h0}, 16, "R7 test");
        frame({2'b11, 14'h0}, 16, rd_tag());
        result = 12'h00F; result_vld = 1'b1; @(negedge clk); result_vld = 1'b0;
        m_result = 12'h00F;
        frame({2'b00, 14'h0}, 16, "R6");
        check_regs("R3");

        // R8: data-out idles low between frames
        check("R8 idle sdo", 32'(sdo), 32'd0);

        finish_run();
    end
endmodule